// File: doc/BRIEF.md
# Capability Access Permission Checker

This block decides whether a memory access may go ahead under a capability whose fields are already decoded: a validity tag, a sealed flag, a permission mask, a lower bound and an upper bound. For each request it also takes the access address, the access size in bytes and the mask of permissions that the access needs. It returns one fault class, or none, together with a store indication for the fault record and the access address.

The checks run in a fixed order: tag, seal, permission bits, execute permission, then bounds. Only the first failing check is reported. Requests enter through a valid/ready handshake. The result is registered and leaves through a second valid/ready handshake one cycle after acceptance. A stalled consumer holds the result steady and blocks new requests.

Top module: `cap_access_checker`

## Requirements
- R1: Fault codes on `rsp_fault_o` are 0 none, 1 tag, 2 seal, 3 permission and 4 bounds. A clear tag gives code 1 whatever every other input holds.
- R2: With the tag set and the sealed flag set, the result is code 2, whatever the permissions and bounds.
- R3: With the tag set and the capability unsealed, code 3 results when any bit set in `acc_perms_i` is clear in `cap_perms_i`. The permission bits are 0 load, 1 store and 2 execute.
- R4: When execute (bit 2) is requested and the capability lacks bit 2, the result is code 3, even if every other requested bit is present.
- R5: Once the tag, seal and permission checks pass, the access is in bounds only when base <= addr and addr+size <= top. The sum is formed in 65 bits, so it cannot wrap. Otherwise the result is code 4. A size of zero at addr == top passes.
- R6: `rsp_store_o` is 1 exactly when the fault code is non-zero and store (bit 1) is set in the requested permissions.
- R7: `rsp_addr_o` equals the address of the request, and with code 0 it is returned unchanged.
- R8: A request is accepted when `req_valid_i` and `req_ready_o` are both high at a clock edge, and `rsp_valid_o` is high one cycle later. `req_ready_o` is high when no result is held or the held result is being taken.
- R9: While `rsp_valid_o` is high and `rsp_ready_i` is low, every response output holds its value and no new request is accepted.
- R10: After reset, `rsp_valid_o` is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| cap_tag_i | input | 1 | Capability tag |
| cap_sealed_i | input | 1 | Capability sealed flag |
| cap_perms_i | input | PERM_W | Capability permission mask |
| cap_base_i | input | ADDR_W | Decoded lower bound |
| cap_top_i | input | ADDR_W+1 | Decoded upper bound, exclusive |
| acc_addr_i | input | ADDR_W | Access address |
| acc_size_i | input | SIZE_W | Access size in bytes |
| acc_perms_i | input | PERM_W | Requested permission mask |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Consumer takes result |
| rsp_fault_o | output | 3 | Fault class |
| rsp_store_o | output | 1 | Fault record store indication |
| rsp_addr_o | output | ADDR_W | Access address returned |

## Verification
The bench stacks several failures into one request so that only the first in the check order may show. A design with the wrong priority would report seal or bounds on an untagged capability, or bounds on a sealed one. It probes the bounds edges: an end exactly at top, one byte past top, and an address near the top of the address space whose sum overflows 64 bits. A design that adds in 64 bits would wrap that sum and pass the access. It also stalls the consumer with results pending, to catch a register that takes new data while the old result is still unread, and checks that the store flag stays low on success and follows the requested store bit on faults.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_TAG    = 3'd1,
    FLT_SEAL   = 3'd2,
    FLT_PERM   = 3'd3,
    FLT_BOUNDS = 3'd4
  } fault_e;
endpackage

// File: rtl/cap_perm_eval.sv
module cap_perm_eval #(
  parameter int PERM_W    = 16,
  parameter int STORE_IDX = 1,
  parameter int EXEC_IDX  = 2
) (
  input  logic [PERM_W-1:0] cap_perms_i,
  input  logic [PERM_W-1:0] acc_perms_i,
  output logic              perm_miss_o,
  output logic              exec_miss_o,
  output logic              store_req_o
);
  logic [PERM_W-1:0] miss;

  for (genvar i = 0; i < PERM_W; i++) begin : g_miss
    assign miss[i] = acc_perms_i[i] & ~cap_perms_i[i];
  end

  assign perm_miss_o = |miss;
  assign exec_miss_o = acc_perms_i[EXEC_IDX] & ~cap_perms_i[EXEC_IDX];
  assign store_req_o = acc_perms_i[STORE_IDX];
endmodule

// File: rtl/cap_bounds_eval.sv
module cap_bounds_eval #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   top_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              in_bounds_o
);
  localparam int EW = ADDR_W + 1;
  logic [EW-1:0] addr_x, end_x;

  // one extra bit keeps addr+size from wrapping
  assign addr_x      = {1'b0, addr_i};
  assign end_x       = addr_x + EW'(size_i);
  assign in_bounds_o = ({1'b0, base_i} <= addr_x) && (end_x <= top_i);
endmodule

// File: rtl/cap_fault_prio.sv
module cap_fault_prio
  import cap_chk_pkg::*;
(
  input  logic   tag_i,
  input  logic   sealed_i,
  input  logic   perm_miss_i,
  input  logic   exec_miss_i,
  input  logic   in_bounds_i,
  output fault_e fault_o
);
  always_comb begin
    if (!tag_i)                         fault_o = FLT_TAG;
    else if (sealed_i)                  fault_o = FLT_SEAL;
    else if (perm_miss_i || exec_miss_i) fault_o = FLT_PERM;
    else if (!in_bounds_i)              fault_o = FLT_BOUNDS;
    else                                fault_o = FLT_NONE;
  end
endmodule

// File: rtl/cap_access_checker.sv
module cap_access_checker
  import cap_chk_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int SIZE_W    = 8,
  parameter int PERM_W    = 16,
  parameter int STORE_IDX = 1,
  parameter int EXEC_IDX  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              cap_tag_i,
  input  logic              cap_sealed_i,
  input  logic [PERM_W-1:0] cap_perms_i,
  input  logic [ADDR_W-1:0] cap_base_i,
  input  logic [ADDR_W:0]   cap_top_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  input  logic [PERM_W-1:0] acc_perms_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [2:0]        rsp_fault_o,
  output logic              rsp_store_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  logic   perm_miss, exec_miss, store_req, in_bounds;
  fault_e fault_d;
  logic   accept;

  cap_perm_eval #(
    .PERM_W(PERM_W), .STORE_IDX(STORE_IDX), .EXEC_IDX(EXEC_IDX)
  ) u_perm (
    .cap_perms_i(cap_perms_i),
    .acc_perms_i(acc_perms_i),
    .perm_miss_o(perm_miss),
    .exec_miss_o(exec_miss),
    .store_req_o(store_req)
  );

  cap_bounds_eval #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bnd (
    .base_i     (cap_base_i),
    .top_i      (cap_top_i),
    .addr_i     (acc_addr_i),
    .size_i     (acc_size_i),
    .in_bounds_o(in_bounds)
  );

  cap_fault_prio u_prio (
    .tag_i      (cap_tag_i),
    .sealed_i   (cap_sealed_i),
    .perm_miss_i(perm_miss),
    .exec_miss_i(exec_miss),
    .in_bounds_i(in_bounds),
    .fault_o    (fault_d)
  );

  logic              vld_q;
  fault_e            fault_q;
  logic              store_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready_o = !vld_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      fault_q <= FLT_NONE;
      store_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (req_ready_o) vld_q <= req_valid_i;
      if (accept) begin
        fault_q <= fault_d;
        store_q <= (fault_d != FLT_NONE) && store_req;
        addr_q  <= acc_addr_i;
      end
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_fault_o = fault_q;
  assign rsp_store_o = store_q;
  assign rsp_addr_o  = addr_q;

  assert_tag_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !cap_tag_i) |=> (rsp_fault_o == 3'd1));

  assert_seal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cap_tag_i && cap_sealed_i) |=> (rsp_fault_o == 3'd2));

  assert_store_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 3'd0) |-> !rsp_store_o);

  assert_addr_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (rsp_addr_o == $past(acc_addr_i)));

  assert_rsp_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_fault_o)
      && $stable(rsp_store_o) && $stable(rsp_addr_o)));

  assert_fault_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o <= 3'd4));
endmodule

// File: tb/tb_cap_access_checker.sv
module tb_cap_access_checker;
  localparam int AW = 64;
  localparam int SW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          c_tag = 1'b0, c_sealed = 1'b0;
  logic [PW-1:0] c_perms = '0;
  logic [AW-1:0] c_base = '0;
  logic [AW:0]   c_top = '0;
  logic [AW-1:0] a_addr = '0;
  logic [SW-1:0] a_size = '0;
  logic [PW-1:0] a_perms = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [2:0]    rsp_fault;
  logic          rsp_store;
  logic [AW-1:0] rsp_addr;

  int checks = 0, errors = 0, sent = 0, got = 0, hold_n = 0;

  typedef struct {
    logic [2:0]    fault;
    logic          store;
    logic [AW-1:0] addr;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  cap_access_checker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .cap_tag_i(c_tag), .cap_sealed_i(c_sealed), .cap_perms_i(c_perms),
    .cap_base_i(c_base), .cap_top_i(c_top),
    .acc_addr_i(a_addr), .acc_size_i(a_size), .acc_perms_i(a_perms),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_fault_o(rsp_fault), .rsp_store_o(rsp_store), .rsp_addr_o(rsp_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW:0] act, input logic [AW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model built from R1..R6
  function automatic logic [2:0] ref_fault(logic tg, logic sl, logic [PW-1:0] cp,
      logic [AW-1:0] b, logic [AW:0] t, logic [AW-1:0] ad, logic [SW-1:0] sz,
      logic [PW-1:0] rp);
    logic [AW:0] e;
    e = {1'b0, ad} + {{(AW+1-SW){1'b0}}, sz};
    if (!tg) return 3'd1;
    if (sl) return 3'd2;
    if ((rp & ~cp) != '0) return 3'd3;
    if (rp[2] && !cp[2]) return 3'd3;
    if (!(b <= ad && e <= t)) return 3'd4;
    return 3'd0;
  endfunction

  task automatic send(input logic tg, input logic sl, input logic [PW-1:0] cp,
      input logic [AW-1:0] b, input logic [AW:0] t, input logic [AW-1:0] ad,
      input logic [SW-1:0] sz, input logic [PW-1:0] rp, input string req);
    exp_t e;
    e.fault = ref_fault(tg, sl, cp, b, t, ad, sz, rp);
    e.store = (e.fault != 3'd0) && rp[1];
    e.addr  = ad;
    e.req   = req;
    sb.push_back(e);
    sent++;
    c_tag = tg; c_sealed = sl; c_perms = cp; c_base = b; c_top = t;
    a_addr = ad; a_size = sz; a_perms = rp;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // consumer backpressure
  always @(posedge clk) begin
    #1;
    if (hold_n > 0) begin rsp_ready = 1'b0; hold_n--; end
    else rsp_ready = 1'b1;
  end

  // monitor
  logic          pend = 1'b0;
  logic [2:0]    p_fault;
  logic          p_store;
  logic [AW-1:0] p_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && rsp_valid) begin
        chk(rsp_fault == p_fault && rsp_store == p_store && rsp_addr == p_addr,
            "R9", "held result", {1'b0, rsp_addr}, {1'b0, p_addr});
      end
      pend = 1'b0;
      if (rsp_valid && !rsp_ready) begin
        pend = 1'b1; p_fault = rsp_fault; p_store = rsp_store; p_addr = rsp_addr;
        chk(!req_ready, "R9", "ready while stalled", {64'd0, req_ready}, '0);
      end
      if (rsp_valid && rsp_ready) begin
        got++;
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected response", {62'd0, rsp_fault}, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_fault == e.fault, e.req, "fault", {62'd0, rsp_fault}, {62'd0, e.fault});
          chk(rsp_store == e.store, "R6", "store", {64'd0, rsp_store}, {64'd0, e.store});
          chk(rsp_addr == e.addr, "R7", "addr", {1'b0, rsp_addr}, {1'b0, e.addr});
        end
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [PW-1:0] P_ALL = 16'h0007;
  localparam logic [PW-1:0] P_LD  = 16'h0001;
  localparam logic [PW-1:0] P_ST  = 16'h0002;
  localparam logic [PW-1:0] P_EX  = 16'h0004;

  initial begin
    repeat (3) @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", "reset state", {63'd0, rsp_valid, req_ready}, 65'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 latency
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h1800, 8, P_LD, "R7");
    chk(rsp_valid, "R8", "valid one cycle after accept", {64'd0, rsp_valid}, 65'd1);
    @(negedge clk);

    // R1 tag first, everything else failing too
    send(0, 1, '0, 64'h1000, 65'h1000, 64'h0, 8, P_ST, "R1");
    send(0, 0, P_ALL, 64'h0, 65'h10000, 64'h10, 4, P_LD, "R1");
    // R2 seal over perms and bounds
    send(1, 1, '0, 64'h1000, 65'h1000, 64'h0, 8, P_LD | P_ST, "R2");
    // R3 missing bits
    send(1, 0, P_LD, 64'h1000, 65'h2000, 64'h1000, 8, P_ST, "R3");
    send(1, 0, 16'h0100, 64'h1000, 65'h2000, 64'h5000, 8, 16'h0200, "R3");
    // R4 execute
    send(1, 0, P_LD | P_ST, 64'h1000, 65'h2000, 64'h1000, 4, P_EX | P_LD, "R4");
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h1000, 4, P_EX, "R4");
    // R5 bounds edges
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h0FFF, 1, P_LD, "R5");
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h1FF8, 8, P_LD, "R5");
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h1FF9, 8, P_ST, "R5");
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h2000, 0, P_LD, "R5");
    send(1, 0, P_ALL, 64'h0, 65'h0_FFFF_FFFF_FFFF_FFF0,
         64'hFFFF_FFFF_FFFF_FFFC, 8, P_LD, "R5");
    send(1, 0, P_ALL, 64'h0, 65'h1_0000_0000_0000_0000,
         64'hFFFF_FFFF_FFFF_FFF8, 8, P_ST, "R5");
    // R6 store on success stays low
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h1100, 16, P_ST, "R6");

    // R9 backpressure with two pending
    @(negedge clk);
    hold_n = 5;
    send(1, 0, P_ALL, 64'h1000, 65'h2000, 64'h1200, 8, P_LD, "R9");
    send(0, 0, P_ALL, 64'h1000, 65'h2000, 64'h1300, 8, P_ST, "R9");
    send(1, 1, P_ALL, 64'h1000, 65'h2000, 64'h1400, 8, P_LD, "R9");

    repeat (20) @(negedge clk);
    chk(sb.size() == 0 && got == sent, "R8", "all responses delivered",
        65'(got), 65'(sent));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule